// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Manager

This block is the device-side bookkeeping for a circular ring of transmit descriptors held in memory. Software produces descriptors and the device consumes them. Software fills one or more descriptors and then writes a new tail index through a register port. The device owns the head index, which names the descriptor it is servicing now.

Whenever the ring holds work and no fetch is in flight, the block presents the memory address of the head descriptor on a valid/ready request port. After the request is accepted, it waits for the downstream engine to report that descriptor done. The done report advances the head, with wrap-around.

The block exposes the head, the tail, empty and full flags, and the number of descriptors still pending. It also gives a one-cycle interrupt pulse when the head catches up with the tail. Any tail write that would move the tail past the head is refused, and a sticky error flag records the refusal.

Top module: `txring_ptr_mgr`

## Requirements
- R1: After reset, head and tail are 0, pending is 0, empty is 1, full is 0, the overflow flag is 0, the interrupt is 0 and no fetch request is valid.
- R2: Pending equals (tail − head) modulo RING_DEPTH (default 16). Empty is 1 exactly when head equals tail. Full is 1 exactly when pending equals RING_DEPTH − 1, so one slot always stays unused.
- R3: A tail write whose value v satisfies ((v − head) mod RING_DEPTH) ≥ pending is accepted. The tail takes v in the cycle after the write, and a single write may hand over several descriptors, including across the wrap point.
- R4: A tail write that fails the R3 test would move the tail onto or past the head. It leaves the tail unchanged and sets the overflow flag, and the overflow flag then stays 1 until reset.
- R5: When the ring is not empty and no fetch is in flight, the fetch request becomes valid one cycle later. Its address is base + head × 16. Valid and address hold steady until ready is seen, and valid drops in the cycle after the handshake.
- R6: A done pulse advances the head by one modulo RING_DEPTH only while a fetch is in flight, meaning it has been accepted and not yet completed. A done pulse at any other time leaves the head unchanged.
- R7: When a done pulse makes the head equal the tail, the interrupt is 1 for exactly the one cycle after that pulse.
- R8: At most one fetch is in flight. No new request becomes valid between the handshake and the matching done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | ADDR_W | Byte address of ring slot 0 |
| tailWrEn | input | 1 | Software writes a new tail index this cycle |
| tailWrData | input | PTR_W | Tail index being written |
| fetchValid | output | 1 | Descriptor fetch request valid |
| fetchReady | input | 1 | Fetch request accepted by memory side |
| fetchAddr | output | ADDR_W | Byte address of the head descriptor |
| descDone | input | 1 | Downstream engine finished the fetched descriptor |
| headPtr | output | PTR_W | Current head index |
| tailPtr | output | PTR_W | Current tail index |
| pendingCnt | output | PTR_W | Descriptors between head and tail |
| ringEmpty | output | 1 | Head equals tail |
| ringFull | output | 1 | One slot left free, no more can be posted |
| overflowErr | output | 1 | Sticky flag for a refused tail write |
| idleIrq | output | 1 | One-cycle pulse when the head reaches the tail |

## Verification
Tail, head, pending, the flags, the overflow bit and the interrupt are all registered. The bench therefore samples them one nanosecond after the clock edge that captured the write or done pulse, so each is checked in the cycle right after its stimulus.

The fetch request lags by one more cycle, because it is raised by the control state that sees the non-empty ring. The bench polls for valid for a bounded number of cycles rather than guessing the edge. It then checks that valid is gone one cycle after the ready handshake. Done pulses given while no fetch is in flight are checked through the unchanged head at the same sampling point.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef struct packed {
    logic loadTail;
    logic setOvf;
    logic advHead;
  } ringStrobe_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetchState_t;
endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 16,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  localparam int PTR_W     = $clog2(RING_DEPTH),
  localparam int DESC_SH   = $clog2(DESC_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strb,
  input  logic [PTR_W-1:0]  tailWrData,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              tailOk,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic [PTR_W-1:0]  pendingCnt,
  output logic              ringEmpty,
  output logic              ringFull,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              overflowErr,
  output logic              idleIrq
);
  logic [PTR_W-1:0] headQ, tailQ, headNext, tailNext, wrDist;
  logic             ovfQ, irqQ;

  // Ring distance from head to the proposed tail.
  assign wrDist     = tailWrData - headQ;
  assign pendingCnt = tailQ - headQ;
  assign tailOk     = (wrDist >= pendingCnt);
  assign ringEmpty  = (headQ == tailQ);
  assign ringFull   = (pendingCnt == PTR_W'(RING_DEPTH - 1));

  assign headNext = strb.advHead  ? headQ + PTR_W'(1) : headQ;
  assign tailNext = strb.loadTail ? tailWrData         : tailQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      ovfQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      headQ <= headNext;
      tailQ <= tailNext;
      if (strb.setOvf) ovfQ <= 1'b1;
      irqQ  <= strb.advHead && (headNext == tailNext);
    end
  end

  assign fetchAddr   = baseAddr + (ADDR_W'(headQ) << DESC_SH);
  assign headPtr     = headQ;
  assign tailPtr     = tailQ;
  assign overflowErr = ovfQ;
  assign idleIrq     = irqQ;

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(headQ) |-> (headQ == $past(headQ) + PTR_W'(1))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ); // R4
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> ringEmpty); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ || $past(strb.advHead)); // R7
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tailWrEn,
  input  logic        tailOk,
  input  logic        ringEmpty,
  input  logic        fetchReady,
  input  logic        descDone,
  output ringStrobe_t strb,
  output logic        fetchValid
);
  fetchState_t stQ, stNext;

  always_comb begin
    stNext = stQ;
    unique case (stQ)
      FS_IDLE: if (!ringEmpty) stNext = FS_REQ;
      FS_REQ:  if (fetchReady) stNext = FS_WAIT;
      FS_WAIT: if (descDone)   stNext = FS_IDLE;
      default: stNext = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= FS_IDLE;
    else       stQ <= stNext;
  end

  assign fetchValid    = (stQ == FS_REQ);
  assign strb.advHead  = (stQ == FS_WAIT) && descDone;
  assign strb.loadTail = tailWrEn && tailOk;
  assign strb.setOvf   = tailWrEn && !tailOk;

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !fetchReady |=> fetchValid); // R5
  AST_NO_FETCH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> !ringEmpty); // R5
  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && fetchReady |=> !fetchValid); // R8
endmodule

// File: rtl/txring_ptr_mgr.sv
module txring_ptr_mgr
  import txring_pkg::*;
#(
  parameter int RING_DEPTH = 16,
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  localparam int PTR_W     = $clog2(RING_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              tailWrEn,
  input  logic [PTR_W-1:0]  tailWrData,
  output logic              fetchValid,
  input  logic              fetchReady,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              descDone,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic [PTR_W-1:0]  pendingCnt,
  output logic              ringEmpty,
  output logic              ringFull,
  output logic              overflowErr,
  output logic              idleIrq
);
  ringStrobe_t strb;
  logic        tailOk;

  txring_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tailWrEn   (tailWrEn),
    .tailOk     (tailOk),
    .ringEmpty  (ringEmpty),
    .fetchReady (fetchReady),
    .descDone   (descDone),
    .strb       (strb),
    .fetchValid (fetchValid)
  );

  txring_datapath #(
    .RING_DEPTH (RING_DEPTH),
    .ADDR_W     (ADDR_W),
    .DESC_BYTES (DESC_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .tailWrData  (tailWrData),
    .baseAddr    (baseAddr),
    .tailOk      (tailOk),
    .headPtr     (headPtr),
    .tailPtr     (tailPtr),
    .pendingCnt  (pendingCnt),
    .ringEmpty   (ringEmpty),
    .ringFull    (ringFull),
    .fetchAddr   (fetchAddr),
    .overflowErr (overflowErr),
    .idleIrq     (idleIrq)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !fetchReady |=> $stable(fetchAddr)); // R5
endmodule

// File: tb/sim_txring_ptr_mgr.sv
`timescale 1ns/1ps
module sim_txring_ptr_mgr;
  localparam int DEPTH = 16;
  localparam int PW    = 4;
  localparam logic [31:0] BASE = 32'h8000_1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   baseAddr = BASE;
  logic          tailWrEn = 1'b0;
  logic [PW-1:0] tailWrData = '0;
  logic          fetchValid, fetchReady = 1'b0, descDone = 1'b0;
  logic [31:0]   fetchAddr;
  logic [PW-1:0] headPtr, tailPtr, pendingCnt;
  logic          ringEmpty, ringFull, overflowErr, idleIrq;

  int nChecks = 0;
  int nFails  = 0;
  int mHead   = 0;
  int mTail   = 0;

  always #2 clk = ~clk;

  txring_ptr_mgr u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr),
    .tailWrEn(tailWrEn), .tailWrData(tailWrData),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchAddr(fetchAddr),
    .descDone(descDone), .headPtr(headPtr), .tailPtr(tailPtr),
    .pendingCnt(pendingCnt), .ringEmpty(ringEmpty), .ringFull(ringFull),
    .overflowErr(overflowErr), .idleIrq(idleIrq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input longint got, input longint exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chkFlags(input string req);
    int p;
    p = (mTail - mHead + DEPTH) % DEPTH;
    chk(req, "head", headPtr, mHead);
    chk(req, "tail", tailPtr, mTail);
    chk(req, "pending", pendingCnt, p);
    chk(req, "empty", ringEmpty, p == 0);
    chk(req, "full", ringFull, p == DEPTH - 1);
  endtask

  task automatic writeTail(input int v, input bit expOk);
    tailWrEn = 1'b1; tailWrData = PW'(v);
    tick();
    tailWrEn = 1'b0;
    if (expOk) mTail = v;
    chkFlags(expOk ? "R3" : "R4");
  endtask

  task automatic serviceOne();
    int n;
    bit expIrq;
    n = 0;
    while (!fetchValid && n < 8) begin tick(); n++; end
    chk("R5", "fetch valid", fetchValid, 1);
    chk("R5", "fetch addr", fetchAddr, BASE + 32'(mHead * 16));
    fetchReady = 1'b1;
    tick();
    fetchReady = 1'b0;
    chk("R5", "valid drops after handshake", fetchValid, 0);
    tick();
    chk("R8", "no second request in flight", fetchValid, 0);
    descDone = 1'b1;
    tick();
    descDone = 1'b0;
    mHead  = (mHead + 1) % DEPTH;
    expIrq = (mHead == mTail);
    chkFlags("R6");
    chk("R7", "irq after done", idleIrq, expIrq);
    if (expIrq) begin
      tick();
      chk("R7", "irq one cycle", idleIrq, 0);
    end
  endtask

  task automatic testReset();
    chkFlags("R1");
    chk("R1", "overflow", overflowErr, 0);
    chk("R1", "irq", idleIrq, 0);
    chk("R1", "fetch valid", fetchValid, 0);
  endtask

  task automatic testBatchAndHold();
    writeTail(3, 1'b1);
    tick();
    chk("R5", "valid one cycle after non-empty", fetchValid, 1);
    chk("R5", "addr at head 0", fetchAddr, BASE);
    descDone = 1'b1;
    tick();
    descDone = 1'b0;
    chk("R6", "done before handshake ignored", headPtr, 0);
    repeat (2) tick();
    chk("R5", "valid held", fetchValid, 1);
    chk("R5", "addr held", fetchAddr, BASE);
    serviceOne();
    writeTail(5, 1'b1);
    serviceOne();
    serviceOne();
    serviceOne();
    serviceOne();
    chk("R2", "empty after drain", ringEmpty, 1);
  endtask

  task automatic testIdleDone();
    descDone = 1'b1;
    tick();
    descDone = 1'b0;
    chk("R6", "idle done ignored", headPtr, mHead);
    chk("R7", "no irq on idle done", idleIrq, 0);
    repeat (2) tick();
    chk("R5", "no fetch when empty", fetchValid, 0);
  endtask

  task automatic testFullAndOverflow();
    writeTail((mHead + DEPTH - 1) % DEPTH, 1'b1);
    chk("R2", "full flag", ringFull, 1);
    chk("R4", "no overflow yet", overflowErr, 0);
    writeTail(mHead, 1'b0);
    chk("R4", "overflow set", overflowErr, 1);
    writeTail((mHead + DEPTH - 2) % DEPTH, 1'b0);
    chk("R4", "overflow sticky", overflowErr, 1);
  endtask

  task automatic testWrapDrain();
    for (int i = 0; i < DEPTH - 1; i++) serviceOne();
    chk("R6", "head wrapped to tail", headPtr, mTail);
    chk("R4", "overflow still sticky", overflowErr, 1);
  endtask

  initial begin
    #(4 * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    testReset();
    testBatchAndHold();
    testIdleDone();
    testFullAndOverflow();
    testWrapDrain();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule